// File: doc/BRIEF.md
# MDIO Management Register Controller

This block runs one Clause-22 management transaction at a time on the two-wire MDC/MDIO bus of an external PHY. All control passes through a single 32-bit register word. A write to that word holds the PHY address, the PHY register number and, for a write, the 16-bit data. It also holds one of two command bits. While the bus cycle runs the controller shows a busy flag in the same word. When a read ends, it places the returned value in the upper half of the word and raises a not-valid flag if the PHY never answered.

MDC is made from the system clock by a divider. It runs only while a transaction is in flight and stays low at all other times. Each frame is 64 bits long, most significant bit first: 32 preamble ones, start pattern 01, the opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register number, two turnaround bits and 16 data bits. For a read, the controller releases MDIO from the first turnaround bit to the end of the frame.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the word reads zero, except the PHY address field [15:11], which holds the parameter RST_PHY_ADDR. MDC is low and the MDIO output enable is low.
- R2: A write while idle with bits [1:0] both zero stores data [31:16], PHY address [15:11] and register number [10:6] for read-back, and starts no bus activity. Bits [2:0] and [5] always read as zero.
- R3: Setting bit 0 starts a write frame. On each MDC rise the bus carries 32 ones, 01, 01, the PHY address, the register number, 10 and the data, MSB first, with the output enable high for all 64 bits.
- R4: Setting bit 1 starts a read frame that carries opcode 10. The output enable is high for the first 46 bits and low for the last 18 bits, which are the turnaround and data bits.
- R5: At the end of a read, bits [31:16] hold the 16 bits sampled on the MDC rises of the data phase. Bit 4 (not-valid) is 0 when the PHY held the second turnaround bit low.
- R6: At the end of a read in which the second turnaround bit sampled high, bit 4 reads 1.
- R7: Bit 3 (busy) reads 1 from the cycle after the accepted command write for exactly 128*DIV_HALF cycles, then returns to 0.
- R8: MDC has a period of 2*DIV_HALF system clocks while busy and is low while idle. MDIO output does not change while MDC is high.
- R9: A register write while busy is ignored. The fields keep their values, the frame in flight is unchanged, and no second frame follows.
- R10: A command with both bits 0 and 1 set runs a read.
- R11: A write arriving in the same cycle that the frame ends is ignored, because busy still reads 1. A write one cycle later is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe for the command/status word |
| reg_wdata_i | input | 32 | Write data for the command/status word |
| reg_rdata_o | output | 32 | Current command/status word |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable (high = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Two events can meet on one clock edge: the final falling MDC strobe that ends a frame, and a software write to the word. The bench counts system clocks from the accepted command edge and places a second command exactly on the 128*DIV_HALF-th edge after it. It then checks that busy has dropped, that the fields still hold the first command, and that MDC stays quiet. A command written one cycle later must raise busy again. A write issued in the middle of a frame is also checked for having no effect on the fields or the serial bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int IW = 6;
  localparam logic [IW-1:0] REL_IDX  = 6'd46;  // first turnaround bit
  localparam logic [IW-1:0] TA2_IDX  = 6'd47;
  localparam logic [IW-1:0] DAT_IDX  = 6'd48;
  localparam logic [IW-1:0] LAST_IDX = 6'd63;

  localparam int DATA_LSB = 16;
  localparam int PHY_LSB  = 11;
  localparam int REG_LSB  = 6;
  localparam int NV_BIT   = 4;
  localparam int BUSY_BIT = 3;
  localparam int RD_BIT   = 1;
  localparam int WR_BIT   = 0;

  function automatic logic [FRAME_LEN-1:0] build_frame(input logic rd, input logic [4:0] phy,
                                                      input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == CNT_TOP);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  a_r8_mdc_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mdc_q);
  a_r8_mdc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        is_read_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        rd_done_o,
  output logic [15:0] rdata_o,
  output logic        nvalid_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [IW-1:0]        idx_q, idx_nx;
  logic                 busy_q, rd_q, oe_q, dout_q, nv_q;
  logic [15:0]          rsh_q;

  assign idx_nx    = idx_q + 6'd1;
  assign done_o    = busy_q && fall_i && (idx_q == LAST_IDX);
  assign rd_done_o = done_o && rd_q;
  assign busy_o    = busy_q;
  assign rdata_o   = rsh_q;
  assign nvalid_o  = nv_q;
  assign mdio_o    = dout_q;
  assign mdio_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
      nv_q   <= 1'b0;
      rsh_q  <= '0;
    end else if (start_i && !busy_q) begin
      sh_q   <= build_frame(is_read_i, phy_i, reg_i, wdata_i);
      dout_q <= 1'b1;  // first preamble bit
      oe_q   <= 1'b1;
      idx_q  <= '0;
      busy_q <= 1'b1;
      rd_q   <= is_read_i;
      nv_q   <= 1'b0;
    end else if (busy_q) begin
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          dout_q <= 1'b0;
        end else begin
          idx_q  <= idx_nx;
          sh_q   <= sh_q << 1;
          dout_q <= sh_q[FRAME_LEN-2];
          oe_q   <= !(rd_q && (idx_nx >= REL_IDX));
        end
      end
      if (rise_i && rd_q) begin
        if (idx_q == TA2_IDX) nv_q <= mdio_i;
        if (idx_q >= DAT_IDX) rsh_q <= {rsh_q[14:0], mdio_i};
      end
    end
  end

  a_r7_busy_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q);
  a_r8_dout_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> $stable(dout_q));
  a_r4_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_q && (idx_q >= REL_IDX)) |-> !oe_q);
  a_r3_write_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rd_q) |-> oe_q);
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !oe_q);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int          DIV_HALF     = 4,
  parameter logic [4:0]  RST_PHY_ADDR = 5'd0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [15:0] data_q;
  logic [4:0]  phy_q, reg_q;
  logic        nv_q;
  logic        busy, done, rd_done, rise, fall, seq_nv;
  logic [15:0] seq_rdata;
  logic        accept, start, is_read;
  logic        unused_bits;

  assign unused_bits = ^{reg_wdata_i[5:2]};
  assign accept  = reg_we_i && !busy;
  assign start   = accept && (reg_wdata_i[RD_BIT] || reg_wdata_i[WR_BIT]);
  assign is_read = reg_wdata_i[RD_BIT];  // read wins when both set

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      phy_q  <= RST_PHY_ADDR;
      reg_q  <= '0;
      nv_q   <= 1'b0;
    end else if (accept) begin
      data_q <= reg_wdata_i[DATA_LSB +: 16];
      phy_q  <= reg_wdata_i[PHY_LSB +: 5];
      reg_q  <= reg_wdata_i[REG_LSB +: 5];
      if (start) nv_q <= 1'b0;
    end else if (rd_done) begin
      data_q <= seq_rdata;
      nv_q   <= seq_nv;
    end
  end

  mdio_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .is_read_i (is_read),
    .phy_i     (reg_wdata_i[PHY_LSB +: 5]),
    .reg_i     (reg_wdata_i[REG_LSB +: 5]),
    .wdata_i   (reg_wdata_i[DATA_LSB +: 16]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .rd_done_o (rd_done),
    .rdata_o   (seq_rdata),
    .nvalid_o  (seq_nv),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[DATA_LSB +: 16] = data_q;
    reg_rdata_o[PHY_LSB +: 5]   = phy_q;
    reg_rdata_o[REG_LSB +: 5]   = reg_q;
    reg_rdata_o[NV_BIT]         = nv_q;
    reg_rdata_o[BUSY_BIT]       = busy;
  end

  a_r9_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i) |=> ($stable(phy_q) && $stable(reg_q)));
  a_r11_end_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && reg_we_i) |=> !busy);
  a_r7_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
endmodule

// File: tb/mdio_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_ctrl_tb;
  localparam int D = 3;
  localparam logic [4:0] RST_PHY = 5'h15;
  localparam int TXN = 128 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic mdc, mdo, moe, mdi;

  always #10 clk = !clk;

  mdio_ctrl #(.DIV_HALF(D), .RST_PHY_ADDR(RST_PHY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi));

  int checks = 0, fails = 0;
  logic finished = 1'b0;

  // bus monitor and PHY model
  logic cap_d [64];
  logic cap_oe[64];
  int   rise_cnt = 0, rise_total = 0, per_err = 0, stab_err = 0;
  longint cyc = 0, last_rise = 0;
  logic prev_mdc = 1'b0, prev_mdo = 1'b0;
  logic phy_on = 1'b0, phy_drv = 1'b0, phy_val = 1'b1;
  logic [15:0] phy_data = '0;

  assign mdi = phy_drv ? phy_val : (moe ? mdo : 1'b1);

  always @(negedge clk) begin
    cyc++;
    if (mdc && !prev_mdc) begin
      if (rise_cnt < 64) begin
        cap_d[rise_cnt]  = mdo;
        cap_oe[rise_cnt] = moe;
      end
      if (rise_cnt > 0 && (cyc - last_rise) != 2 * D) per_err++;
      last_rise = cyc;
      rise_cnt++;
      rise_total++;
    end
    if (mdc && prev_mdc && mdo != prev_mdo) stab_err++;
    if (!mdc && prev_mdc) begin
      phy_drv = phy_on && rise_cnt >= 47 && rise_cnt <= 63;
      phy_val = (rise_cnt == 47) ? 1'b0 : ((rise_cnt >= 48 && rise_cnt <= 63) ? phy_data[63 - rise_cnt] : 1'b1);
    end
    prev_mdc = mdc;
    prev_mdo = mdo;
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [15:0] d, input logic [4:0] p,
                                      input logic [4:0] r, input logic [1:0] op);
    return {d, p, r, 4'b0, op};
  endfunction

  function automatic logic [63:0] frame(input logic rd, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (rdata[3] && n < 10 * TXN) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input string req, input logic rd, input logic [63:0] f);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      if (rd && i >= 46) begin
        if (cap_oe[i]) bad++;
      end else if (!cap_oe[i] || cap_d[i] != f[63 - i]) bad++;
    end
    check(bad == 0 && rise_cnt == 64, req, bad, 0);
  endtask

  task automatic t_reset();
    check(rdata == {16'h0, RST_PHY, 11'h0}, "R1", rdata, {16'h0, RST_PHY, 11'h0});
    check(!mdc && !moe, "R1", {mdc, moe}, 0);
  endtask

  task automatic t_idle_store();
    int t0 = rise_total;
    wr(cmd(16'hBEEF, 5'h0C, 5'h11, 2'b00) | 32'h0000_003C);
    repeat (4 * D) @(negedge clk);
    check(rdata == cmd(16'hBEEF, 5'h0C, 5'h11, 2'b00), "R2", rdata, cmd(16'hBEEF, 5'h0C, 5'h11, 2'b00));
    check(rise_total == t0 && !moe, "R2", rise_total - t0, 0);
  endtask

  task automatic t_write();
    int n;
    rise_cnt = 0; per_err = 0; stab_err = 0; phy_on = 1'b0;
    wr(cmd(16'hA55A, 5'h13, 5'h0A, 2'b01));
    wait_idle(n);
    check_frame("R3", 1'b0, frame(1'b0, 5'h13, 5'h0A, 16'hA55A));
    check(n == TXN, "R7", n, TXN);
    check(per_err == 0 && stab_err == 0, "R8", per_err + stab_err, 0);
    check(!mdc && !moe, "R8", {mdc, moe}, 0);
    check(rdata == cmd(16'hA55A, 5'h13, 5'h0A, 2'b00), "R3", rdata, cmd(16'hA55A, 5'h13, 5'h0A, 2'b00));
  endtask

  task automatic t_read(input logic present, input logic [15:0] d, input logic [1:0] op, input string req);
    int n;
    logic [15:0] exp_d;
    rise_cnt = 0; phy_on = present; phy_data = d;
    wr(cmd(16'h0000, 5'h01, 5'h02, op));
    wait_idle(n);
    phy_on = 1'b0;
    check_frame(req, 1'b1, frame(1'b1, 5'h01, 5'h02, 16'h0));
    exp_d = present ? d : 16'hFFFF;
    check(rdata[31:16] == exp_d, "R5", rdata[31:16], exp_d);
    check(rdata[4] == !present, present ? "R5" : "R6", rdata[4], !present);
  endtask

  task automatic t_busy_ignore();
    int n, t0;
    rise_cnt = 0;
    wr(cmd(16'h1357, 5'h07, 5'h03, 2'b01));
    repeat (50) @(negedge clk);
    wr(cmd(16'hFFFF, 5'h1F, 5'h1F, 2'b10));
    check(rdata[15:6] == {5'h07, 5'h03} && rdata[3], "R9", rdata, {5'h07, 5'h03});
    wait_idle(n);
    check_frame("R9", 1'b0, frame(1'b0, 5'h07, 5'h03, 16'h1357));
    t0 = rise_total;
    repeat (6 * D) @(negedge clk);
    check(rise_total == t0 && rdata == cmd(16'h1357, 5'h07, 5'h03, 2'b00), "R9", rdata, cmd(16'h1357, 5'h07, 5'h03, 2'b00));
  endtask

  task automatic t_collision();
    int n;
    rise_cnt = 0;
    wr(cmd(16'h2468, 5'h09, 5'h04, 2'b01));
    repeat (TXN - 1) @(negedge clk);
    we = 1'b1; wdata = cmd(16'h0F0F, 5'h1A, 5'h1B, 2'b01);
    @(negedge clk);
    we = 1'b0;
    check(!rdata[3] && rdata[15:6] == {5'h09, 5'h04}, "R11", rdata, cmd(16'h2468, 5'h09, 5'h04, 2'b00));
    check(rise_cnt == 64 && !mdc, "R11", rise_cnt, 64);
    rise_cnt = 0;
    wr(cmd(16'h0F0F, 5'h1A, 5'h1B, 2'b01));
    check(rdata[3] == 1'b1, "R11", rdata[3], 1);
    wait_idle(n);
    check_frame("R11", 1'b0, frame(1'b0, 5'h1A, 5'h1B, 16'h0F0F));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_store();
    t_write();
    t_read(1'b1, 16'h1234, 2'b10, "R4");
    t_read(1'b0, 16'h0000, 2'b10, "R6");
    t_read(1'b1, 16'h8001, 2'b11, "R10");
    t_busy_ignore();
    t_collision();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule